// File: doc/BRIEF.md
# Eight-Opcode Multicycle Processor Core

This block is a small multicycle processor with 32-bit words and eight 32-bit general registers. It decodes a 3-bit opcode and runs eight instructions: add, bitwise nor, load word, store word, branch-if-equal, jump-and-link through a register, halt and noop. Instruction fetch and data access share one word-addressed memory port. The program counter counts in words. A read returns its data on the cycle after the address is presented.

A control state machine moves each instruction through a fixed set of states. Fetch is `ST_FETCH`, which drives PC on the port. In `ST_DECODE` the instruction word is latched and both source registers are read. In `ST_EXEC` the result is computed and the PC is updated. The path after `ST_EXEC` depends on the opcode:

- add, nor and jalr go to `ST_ALUWB`, then back to `ST_FETCH`.
- lw goes to `ST_MEMRD`, then `ST_LOADWB`, then `ST_FETCH`.
- sw goes to `ST_MEMWR`, then `ST_FETCH`.
- beq and noop go straight back to `ST_FETCH`.
- halt goes to `ST_HALTED`, which the machine never leaves.

Reset returns the machine to `ST_FETCH` with PC 0 and all registers cleared. A test harness preloads a program into its memory model and watches the stores and the halted flag.

Top module: `mc8_core`

## Requirements
- R1: While reset is held, and in the first cycle after it is released, mem_addr is 0, mem_we is low and halted is low.
- R2: The opcode sits in bits 24..22 of the instruction word, with these codes: 000 add, 001 nor, 010 lw, 011 sw, 100 beq, 101 jalr, 110 halt, 111 noop. The first source register (A) is in bits 21..19 and the second (B) is in bits 18..16. The add/nor destination is in bits 2..0. For lw, sw and beq, bits 15..0 hold a two's-complement offset that is sign-extended.
- R3: add writes the 32-bit sum of A and B into the destination register, wrapping modulo 2^32.
- R4: nor writes the bitwise NOR of A and B into the destination register.
- R5: Register 0 always reads as zero, and any write to it is discarded.
- R6: lw loads register B from the word at address A + offset. Negative offsets are allowed.
- R7: sw writes register B to the word at address A + offset. The write lasts exactly one cycle, with mem_we high.
- R8: When A equals B, beq sets the next PC to PC+1+offset, where the offset may be negative. Otherwise the next PC is PC+1.
- R9: jalr stores PC+1 into B and jumps to the value that A held before the instruction. When A and B name the same register, the net result is a jump to PC+1.
- R10: halt advances the PC and then raises halted permanently. After that, mem_addr holds the advanced PC and no further writes occur.
- R11: noop changes nothing except advancing the PC.
- R12: Cycle cost per instruction:

  | Instruction | Cycles |
  |---|---|
  | beq, noop, halt | 3 |
  | add, nor, jalr, sw | 4 |
  | lw | 5 |

  Read data is used one cycle after its address.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mem_addr | output | ADDR_W | Word address for fetch, load or store |
| mem_we | output | 1 | Write strobe for a store |
| mem_wdata | output | DATA_W | Store data (register B) |
| mem_rdata | input | DATA_W | Read data, valid one cycle after the address |
| halted | output | 1 | High once halt has retired |

## Verification
A corrupted register or a wrong PC shows up first as a store that has the wrong address or data. It can also appear as a store that should not happen at all. Every such store is compared with the scoreboard in the cycle it occurs. A state machine that takes an extra state or skips one changes the cycle total counted up to halted. A path from the halted state shows as mem_addr moving or mem_we rising within one cycle.

// File: rtl/mc8_pkg.sv
`timescale 1ns/1ps
package mc8_pkg;
    // instruction field positions
    localparam int OPC_HI = 24;
    localparam int OPC_LO = 22;
    localparam int RA_LO  = 19;
    localparam int RB_LO  = 16;
    localparam int RD_LO  = 0;
    localparam int OFF_W  = 16;

    typedef enum logic [2:0] {
        OP_ADD  = 3'd0,
        OP_NOR  = 3'd1,
        OP_LW   = 3'd2,
        OP_SW   = 3'd3,
        OP_BEQ  = 3'd4,
        OP_JALR = 3'd5,
        OP_HALT = 3'd6,
        OP_NOOP = 3'd7
    } opcode_e;

    typedef enum logic [2:0] {
        ST_FETCH,
        ST_DECODE,
        ST_EXEC,
        ST_MEMRD,
        ST_LOADWB,
        ST_MEMWR,
        ST_ALUWB,
        ST_HALTED
    } state_e;

    typedef struct packed {
        logic ir_load;
        logic exec_en;
        logic rf_we;
        logic wb_from_mem;
        logic addr_from_res;
        logic mem_we;
        logic halted;
    } ctrl_t;
endpackage

// File: rtl/mc8_regfile.sv
`timescale 1ns/1ps
module mc8_regfile #(
    parameter int DATA_W = 32,
    parameter int NREG   = 8,
    localparam int IDX_W = $clog2(NREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDX_W-1:0]  ra_idx,
    input  logic [IDX_W-1:0]  rb_idx,
    input  logic              wr_en,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] ra_data,
    output logic [DATA_W-1:0] rb_data
);
    logic [DATA_W-1:0] regs_q [NREG];

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
        end else if (wr_en && wr_idx != '0) begin
            regs_q[wr_idx] <= wr_data;
        end
    end

    // index zero is hard-wired to zero on the read side as well
    assign ra_data = (ra_idx == '0) ? '0 : regs_q[ra_idx];
    assign rb_data = (rb_idx == '0) ? '0 : regs_q[rb_idx];
endmodule

// File: rtl/mc8_alu.sv
`timescale 1ns/1ps
module mc8_alu
    import mc8_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16
) (
    input  opcode_e           op,
    input  logic [DATA_W-1:0] opa,
    input  logic [DATA_W-1:0] opb,
    input  logic [DATA_W-1:0] off,
    input  logic [ADDR_W-1:0] pc,
    input  logic              same_reg,
    output logic [DATA_W-1:0] result,
    output logic [ADDR_W-1:0] pc_next
);
    logic [ADDR_W-1:0] pc_inc;
    assign pc_inc = pc + 1'b1;

    always_comb begin
        unique case (op)
            OP_ADD:       result = opa + opb;
            OP_NOR:       result = ~(opa | opb);
            OP_LW, OP_SW: result = opa + off;
            OP_JALR:      result = DATA_W'(pc_inc);
            default:      result = '0;
        endcase
    end

    always_comb begin
        pc_next = pc_inc;
        if (op == OP_BEQ && opa == opb) begin
            pc_next = pc_inc + off[ADDR_W-1:0];
        end else if (op == OP_JALR) begin
            // link lands first, so a shared register yields PC+1
            pc_next = same_reg ? pc_inc : opa[ADDR_W-1:0];
        end
    end
endmodule

// File: rtl/mc8_ctrl.sv
`timescale 1ns/1ps
module mc8_ctrl
    import mc8_pkg::*;
(
    input  logic    clk,
    input  logic    rst_n,
    input  opcode_e op,
    output ctrl_t   ctl
);
    state_e state_q, state_d;

    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_FETCH;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_FETCH:  state_d = ST_DECODE;
            ST_DECODE: state_d = ST_EXEC;
            ST_EXEC: begin
                unique case (op)
                    OP_ADD, OP_NOR, OP_JALR: state_d = ST_ALUWB;
                    OP_LW:                   state_d = ST_MEMRD;
                    OP_SW:                   state_d = ST_MEMWR;
                    OP_HALT:                 state_d = ST_HALTED;
                    default:                 state_d = ST_FETCH;
                endcase
            end
            ST_MEMRD:  state_d = ST_LOADWB;
            ST_LOADWB: state_d = ST_FETCH;
            ST_MEMWR:  state_d = ST_FETCH;
            ST_ALUWB:  state_d = ST_FETCH;
            ST_HALTED: state_d = ST_HALTED;
            default:   state_d = ST_FETCH;
        endcase
    end

    always_comb begin
        ctl = '0;
        unique case (state_q)
            ST_DECODE: ctl.ir_load = 1'b1;
            ST_EXEC:   ctl.exec_en = 1'b1;
            ST_MEMRD:  ctl.addr_from_res = 1'b1;
            ST_LOADWB: begin
                ctl.rf_we       = 1'b1;
                ctl.wb_from_mem = 1'b1;
            end
            ST_MEMWR: begin
                ctl.addr_from_res = 1'b1;
                ctl.mem_we        = 1'b1;
            end
            ST_ALUWB:  ctl.rf_we  = 1'b1;
            ST_HALTED: ctl.halted = 1'b1;
            default: ;
        endcase
    end
endmodule

// File: rtl/mc8_core.sv
`timescale 1ns/1ps
module mc8_core
    import mc8_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 16,
    parameter int NREG   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    output logic [ADDR_W-1:0] mem_addr,
    output logic              mem_we,
    output logic [DATA_W-1:0] mem_wdata,
    input  logic [DATA_W-1:0] mem_rdata,
    output logic              halted
);
    localparam int IDX_W = $clog2(NREG);
    localparam int IR_W  = OPC_HI + 1;

    ctrl_t             ctl;
    logic [IR_W-1:0]   ir_q;
    logic [DATA_W-1:0] opa_q, opb_q, res_q;
    logic [ADDR_W-1:0] pc_q, pc_next;
    logic [DATA_W-1:0] ra_data, rb_data, alu_res, off_ext, wr_data;
    logic [IDX_W-1:0]  wr_idx;
    logic              same_reg;
    opcode_e           op;

    assign op       = opcode_e'(ir_q[OPC_HI:OPC_LO]);
    assign off_ext  = {{(DATA_W-OFF_W){ir_q[OFF_W-1]}}, ir_q[OFF_W-1:0]};
    assign same_reg = ir_q[RA_LO +: IDX_W] == ir_q[RB_LO +: IDX_W];

    // arithmetic results go to the destination field, link and load go to B
    assign wr_idx  = (!ctl.wb_from_mem && (op == OP_ADD || op == OP_NOR))
                     ? ir_q[RD_LO +: IDX_W] : ir_q[RB_LO +: IDX_W];
    assign wr_data = ctl.wb_from_mem ? mem_rdata : res_q;

    mc8_ctrl u_ctrl (
        .clk   (clk),
        .rst_n (rst_n),
        .op    (op),
        .ctl   (ctl)
    );

    mc8_regfile #(.DATA_W(DATA_W), .NREG(NREG)) u_rf (
        .clk     (clk),
        .rst_n   (rst_n),
        .ra_idx  (mem_rdata[RA_LO +: IDX_W]),
        .rb_idx  (mem_rdata[RB_LO +: IDX_W]),
        .wr_en   (ctl.rf_we),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .ra_data (ra_data),
        .rb_data (rb_data)
    );

    mc8_alu #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_alu (
        .op       (op),
        .opa      (opa_q),
        .opb      (opb_q),
        .off      (off_ext),
        .pc       (pc_q),
        .same_reg (same_reg),
        .result   (alu_res),
        .pc_next  (pc_next)
    );

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ir_q  <= '0;
            opa_q <= '0;
            opb_q <= '0;
            res_q <= '0;
            pc_q  <= '0;
        end else begin
            if (ctl.ir_load) begin
                ir_q  <= mem_rdata[IR_W-1:0];
                opa_q <= ra_data;
                opb_q <= rb_data;
            end
            if (ctl.exec_en) begin
                res_q <= alu_res;
                pc_q  <= pc_next;
            end
        end
    end

    assign mem_addr  = ctl.addr_from_res ? res_q[ADDR_W-1:0] : pc_q;
    assign mem_we    = ctl.mem_we;
    assign mem_wdata = opb_q;
    assign halted    = ctl.halted;
endmodule

// File: rtl/mc8_core_chk.sv
`timescale 1ns/1ps
module mc8_core_chk #(
    parameter int ADDR_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mem_we,
    input logic [ADDR_W-1:0] mem_addr,
    input logic              halted
);
    AST_HALT_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n) halted |-> !mem_we); // R10
    AST_HALT_STICKY: assert property (@(posedge clk) disable iff (!rst_n) halted |=> halted); // R10
    AST_HALT_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n) halted |=> $stable(mem_addr)); // R10
    AST_HALT_AFTER_EXEC: assert property (@(posedge clk) disable iff (!rst_n) $rose(halted) |-> $past(!mem_we)); // R10
    AST_STORE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> !mem_we); // R7
    AST_STORE_NOT_HALT: assert property (@(posedge clk) disable iff (!rst_n) mem_we |=> !halted); // R12
endmodule

bind mc8_core mc8_core_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .mem_we   (mem_we),
    .mem_addr (mem_addr),
    .halted   (halted)
);

// File: tb/mc8_core_bench.sv
`timescale 1ns/1ps
module mc8_core_bench;
    import mc8_pkg::*;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 16;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic [ADDR_W-1:0] mem_addr;
    logic              mem_we;
    logic [DATA_W-1:0] mem_wdata;
    logic [DATA_W-1:0] mem_rdata = '0;
    logic              halted;

    always #4 clk = ~clk;   // 125 MHz

    mc8_core u_mc8_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .mem_addr  (mem_addr),
        .mem_we    (mem_we),
        .mem_wdata (mem_wdata),
        .mem_rdata (mem_rdata),
        .halted    (halted)
    );

    // memory model: registered read, one-cycle latency
    logic [31:0] mem [256];
    always @(posedge clk) begin
        if (mem_we) mem[mem_addr[7:0]] <= mem_wdata;
        mem_rdata <= mem[mem_addr[7:0]];
    end

    int checks = 0;
    int errors = 0;
    int cyc    = 0;

    logic [15:0] q_addr [$];
    logic [31:0] q_data [$];
    string       q_tag  [$];

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    task automatic push_store(input logic [15:0] a, input logic [31:0] d, input string tag);
        q_addr.push_back(a);
        q_data.push_back(d);
        q_tag.push_back(tag);
    endtask

    function automatic logic [31:0] enc_r(input logic [2:0] op, input logic [2:0] ra,
                                          input logic [2:0] rb, input logic [2:0] rd);
        return {7'd0, op, ra, rb, 13'd0, rd};
    endfunction

    function automatic logic [31:0] enc_i(input logic [2:0] op, input logic [2:0] ra,
                                          input logic [2:0] rb, input int off);
        return {7'd0, op, ra, rb, 16'(off)};
    endfunction

    // monitor: counts running cycles and scores every store
    always @(negedge clk) begin
        if (rst_n && !halted) begin
            cyc++;
            if (mem_we) begin
                if (q_addr.size() == 0) begin
                    check(1'b0, "R7 R8", "unexpected store address", 32'(mem_addr), 32'h0);
                end else begin
                    logic [15:0] ea;
                    logic [31:0] ed;
                    string       et;
                    ea = q_addr.pop_front();
                    ed = q_data.pop_front();
                    et = q_tag.pop_front();
                    check(mem_addr == ea, et, "store address", 32'(mem_addr), 32'(ea));
                    check(mem_wdata == ed, et, "store data", mem_wdata, ed);
                end
            end
        end
    end

    initial begin
        bit hold_ok;
        for (int i = 0; i < 256; i++) mem[i] = '0;
        // program
        mem[0]  = enc_i(OP_LW,   0, 1, 100);
        mem[1]  = enc_i(OP_LW,   0, 2, 101);
        mem[2]  = enc_r(OP_ADD,  1, 2, 3);
        mem[3]  = enc_i(OP_SW,   0, 3, 120);
        mem[4]  = enc_r(OP_NOR,  1, 2, 4);
        mem[5]  = enc_i(OP_SW,   0, 4, 121);
        mem[6]  = enc_r(OP_ADD,  1, 1, 0);
        mem[7]  = enc_i(OP_SW,   0, 0, 122);
        mem[8]  = enc_i(OP_LW,   0, 5, 102);
        mem[9]  = enc_i(OP_SW,   5, 1, -5);
        mem[10] = enc_i(OP_LW,   5, 6, -28);
        mem[11] = enc_i(OP_SW,   0, 6, 123);
        mem[12] = enc_i(OP_BEQ,  1, 2, 5);
        mem[13] = enc_i(OP_BEQ,  1, 1, 2);
        mem[14] = enc_i(OP_SW,   0, 1, 126);
        mem[15] = enc_i(OP_SW,   0, 1, 127);
        mem[16] = enc_i(OP_LW,   0, 7, 103);
        mem[17] = enc_i(OP_JALR, 7, 6, 0);
        mem[18] = enc_i(OP_SW,   0, 1, 127);
        mem[19] = enc_i(OP_HALT, 0, 0, 0);
        mem[20] = enc_i(OP_SW,   0, 6, 124);
        mem[21] = enc_i(OP_JALR, 6, 6, 0);
        mem[22] = enc_i(OP_SW,   0, 6, 128);
        mem[23] = enc_i(OP_NOOP, 0, 0, 0);
        mem[24] = enc_i(OP_BEQ,  0, 0, 1);
        mem[25] = enc_i(OP_HALT, 0, 0, 0);
        mem[26] = enc_i(OP_LW,   0, 2, 104);
        mem[27] = enc_i(OP_LW,   0, 3, 105);
        mem[28] = enc_r(OP_ADD,  4, 2, 4);
        mem[29] = enc_i(OP_BEQ,  4, 3, 1);
        mem[30] = enc_i(OP_BEQ,  0, 0, -3);
        mem[31] = enc_i(OP_SW,   0, 4, 129);
        mem[32] = enc_i(OP_HALT, 0, 0, 0);
        mem[33] = enc_i(OP_SW,   0, 1, 127);
        // data
        mem[100] = 32'd7;
        mem[101] = 32'hFFFF_FFF0;
        mem[102] = 32'd130;
        mem[103] = 32'd20;
        mem[104] = 32'd1;
        mem[105] = 32'd11;

        // driver: expected stores, in program order
        push_store(16'd120, 32'hFFFF_FFF7, "R2 R3 R6");
        push_store(16'd121, 32'h0000_0008, "R4");
        push_store(16'd122, 32'h0000_0000, "R5");
        push_store(16'd125, 32'h0000_0007, "R7");
        push_store(16'd123, 32'd130,       "R6");
        push_store(16'd124, 32'd18,        "R9");
        push_store(16'd128, 32'd22,        "R9");
        push_store(16'd129, 32'd11,        "R8 R11");

        repeat (3) @(negedge clk);
        check(mem_addr == '0, "R1", "reset mem_addr", 32'(mem_addr), 32'h0);
        check(!mem_we && !halted, "R1", "reset strobes", {30'd0, mem_we, halted}, 32'h0);
        @(posedge clk);
        #1 rst_n = 1'b1;
        @(negedge clk);
        check(mem_addr == '0 && !mem_we, "R1", "first fetch address", 32'(mem_addr), 32'h0);

        for (int i = 0; i < 5000 && !halted; i++) @(negedge clk);

        if (!halted) begin
            check(1'b0, "R10", "watchdog expired, halted", 32'(halted), 32'h1);
        end else begin
            check(cyc == 129, "R12", "cycles until halted", 32'(cyc), 32'd129);
            check(mem_addr == 16'd33, "R10", "address after halt", 32'(mem_addr), 32'd33);
            check(q_addr.size() == 0, "R8", "expected stores left", 32'(q_addr.size()), 32'h0);
            check(mem[126] == 32'h0 && mem[127] == 32'h0, "R8 R9", "skipped store slots",
                  mem[126] | mem[127], 32'h0);
            hold_ok = 1'b1;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (!halted || mem_we || mem_addr != 16'd33) hold_ok = 1'b0;
            end
            check(hold_ok, "R10", "frozen after halt", {31'd0, hold_ok}, 32'h1);
        end

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule